// File: doc/BRIEF.md
# Adaptive Quantum Boundary Generator

This per-core unit decides where one execution quantum stops and the next begins. It watches the retire stage of its core, one retirement per cycle. Each retirement can carry flags: it is a memory operation, that operation touched shared data, it released a lock, it started spinning on a lock, or it was inserted purely for instrumentation. When the selected policy decides that the quantum is over, the unit raises a one-cycle end pulse with a cause code and restarts its bookkeeping for the next quantum.

A 2-bit policy input selects the rule set. Policy 0 (count) ends a quantum only when a programmable number of retired instructions has been reached. Policy 1 (sync-follow) also ends it on any lock release or spin start. Policy 2 (sharing) also ends it once the thread has gone a programmable number of memory operations without touching shared data, after having touched some. Policy 3 (combined) applies both early rules. The instruction-count ceiling applies under every policy.

The control is a three-state machine. `S_FRESH` is a quantum in which no shared access has been seen yet. `S_ARMED` is a quantum in which the private-run window is counting. `S_BOUNDARY` is the first cycle of a new quantum, in which the end pulse is driven. Transitions: any state goes to `S_BOUNDARY` when a boundary fires. Without a boundary, `S_FRESH` and `S_BOUNDARY` go to `S_ARMED` on a shared memory access and to `S_FRESH` otherwise. `S_ARMED` stays in `S_ARMED`.

Top module: `quantum_boundary_gen`

## Requirements
- R1: After reset, `q_end` is 0 and `q_cause` is 0.
- R2: Under every policy, a counted retirement that brings the count of counted retirements in the quantum to `cfg_target` ends the quantum with cause 1 (count). The count is compared as "reached or exceeded", so a target of 0 or 1 ends the quantum on every counted retirement.
- R3: Under policy 1 or 3, a counted retirement flagged as unlock or as spin-start ends the quantum with cause 2 (sync). Under policy 0 or 2 these flags have no effect.
- R4: Under policy 2 or 3, once the quantum has seen a shared memory access, a private memory access ends the quantum with cause 3 (sharing) if it completes `cfg_window` consecutive private memory accesses since the last shared one. Non-memory retirements neither extend nor break the run.
- R5: The private-run window is inactive until a shared access has occurred in the current quantum. A quantum with no shared access ends only through R2 or R3.
- R6: Policy 3 ends a quantum whenever policy 1 or policy 2 would, with the count ceiling still in force.
- R7: When several conditions hold in the same cycle, the cause is sync, then sharing, then count.
- R8: A retirement with `ret_instrum` = 1 is not counted and none of its flags are considered.
- R9: While `ret_valid` is 0, the event flags are ignored.
- R10: The pulse appears in the cycle after the clock edge that samples the triggering retirement and lasts one cycle. The triggering event closes the old quantum. Retirements sampled in the pulse cycle belong to the new quantum, so back-to-back boundaries give back-to-back pulses.
- R11: `q_cause` is 0 whenever `q_end` is 0, and nonzero whenever `q_end` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_policy | input | 2 | Policy: 0 count, 1 sync-follow, 2 sharing, 3 combined |
| cfg_target | input | CNT_W | Instruction count that ends a quantum |
| cfg_window | input | WIN_W | Length of the private-access run that ends a quantum |
| ret_valid | input | 1 | A retirement is presented this cycle |
| ret_instrum | input | 1 | Retirement is instrumentation-only |
| ret_mem | input | 1 | Retirement is a memory operation |
| ret_shared | input | 1 | The memory operation touched shared data |
| ret_unlock | input | 1 | Retirement released a lock |
| ret_spin | input | 1 | Retirement began spinning on a lock |
| q_end | output | 1 | One-cycle quantum-end pulse |
| q_cause | output | 2 | Cause: 0 none, 1 count, 2 sync, 3 sharing |

## Verification
The hardest state to reach from the ports is a cycle where the armed private-run window completes exactly when the count ceiling and a lock flag also land. Priority then decides the cause, and the window's arming must have survived a preceding boundary correctly. The stimulus sweeps all four policies across small targets and windows with a deterministic pseudo-random retirement stream. The stream is dense in private memory operations and sparse in shared ones, so windows arm, run and collide with the count limit often. Short directed sequences then force the three-way collision and the ignored-event cases.

// File: rtl/qb_pkg.sv
`timescale 1ns/1ps
package qb_pkg;

    typedef enum logic [1:0] {
        POL_COUNT = 2'd0,
        POL_SYNC  = 2'd1,
        POL_SHARE = 2'd2,
        POL_BOTH  = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_COUNT = 2'd1,
        CAUSE_SYNC  = 2'd2,
        CAUSE_SHARE = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        S_FRESH    = 2'd0,
        S_ARMED    = 2'd1,
        S_BOUNDARY = 2'd2
    } state_e;

endpackage

// File: rtl/qb_event_filter.sv
`timescale 1ns/1ps
// Qualifies retirements: only valid, non-instrumentation retirements count.
module qb_event_filter (
    input  logic ret_valid,
    input  logic ret_instrum,
    input  logic ret_mem,
    input  logic ret_shared,
    input  logic ret_unlock,
    input  logic ret_spin,
    output logic counted,
    output logic priv_op,
    output logic shr_op,
    output logic sync_ev
);
    always_comb begin
        counted = ret_valid && !ret_instrum;
        priv_op = counted && ret_mem && !ret_shared;
        shr_op  = counted && ret_mem && ret_shared;
        sync_ev = counted && (ret_unlock || ret_spin);
    end
endmodule

// File: rtl/qb_insn_counter.sv
`timescale 1ns/1ps
// Counts qualified retirements in the current quantum; flags the limit.
module qb_insn_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    input  logic [CNT_W-1:0] target,
    output logic             hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_plus;

    always_comb begin
        cnt_plus = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        hit      = inc && (cnt_plus >= {1'b0, target});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (inc && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_plus[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/qb_share_window.sv
`timescale 1ns/1ps
// Length of the current run of private memory accesses since the last
// shared one; flags completion of the window while armed.
module qb_share_window #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             armed,
    input  logic             priv_op,
    input  logic             shr_op,
    input  logic [WIN_W-1:0] window,
    output logic             hit
);
    localparam logic [WIN_W-1:0] RUN_MAX = {WIN_W{1'b1}};

    logic [WIN_W-1:0] run_q;
    logic [WIN_W:0]   run_plus;

    always_comb begin
        run_plus = {1'b0, run_q} + {{WIN_W{1'b0}}, 1'b1};
        hit      = armed && priv_op && (run_plus >= {1'b0, window});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (clear || shr_op) begin
            run_q <= '0;
        end else if (armed && priv_op && run_q != RUN_MAX) begin
            run_q <= run_plus[WIN_W-1:0];
        end
    end
endmodule

// File: rtl/quantum_boundary_gen.sv
`timescale 1ns/1ps
module quantum_boundary_gen
    import qb_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_policy,
    input  logic [CNT_W-1:0] cfg_target,
    input  logic [WIN_W-1:0] cfg_window,
    input  logic             ret_valid,
    input  logic             ret_instrum,
    input  logic             ret_mem,
    input  logic             ret_shared,
    input  logic             ret_unlock,
    input  logic             ret_spin,
    output logic             q_end,
    output logic [1:0]       q_cause
);
    logic   counted, priv_op, shr_op, sync_ev;
    logic   cnt_hit, win_hit;
    logic   en_sync, en_share;
    logic   fire, armed;
    state_e state_q, state_d;
    cause_e cause_q, cause_d;

    qb_event_filter u_filt (
        .ret_valid   (ret_valid),
        .ret_instrum (ret_instrum),
        .ret_mem     (ret_mem),
        .ret_shared  (ret_shared),
        .ret_unlock  (ret_unlock),
        .ret_spin    (ret_spin),
        .counted     (counted),
        .priv_op     (priv_op),
        .shr_op      (shr_op),
        .sync_ev     (sync_ev)
    );

    qb_insn_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (fire),
        .inc    (counted),
        .target (cfg_target),
        .hit    (cnt_hit)
    );

    assign armed = (state_q == S_ARMED);

    qb_share_window #(.WIN_W(WIN_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (fire),
        .armed   (armed),
        .priv_op (priv_op),
        .shr_op  (shr_op),
        .window  (cfg_window),
        .hit     (win_hit)
    );

    // Policy decode
    always_comb begin
        unique case (policy_e'(cfg_policy))
            POL_COUNT: begin en_sync = 1'b0; en_share = 1'b0; end
            POL_SYNC:  begin en_sync = 1'b1; en_share = 1'b0; end
            POL_SHARE: begin en_sync = 1'b0; en_share = 1'b1; end
            POL_BOTH:  begin en_sync = 1'b1; en_share = 1'b1; end
            default:   begin en_sync = 1'b0; en_share = 1'b0; end
        endcase
    end

    // Boundary decision with fixed priority: sync, sharing, count
    always_comb begin
        if (en_sync && sync_ev)        cause_d = CAUSE_SYNC;
        else if (en_share && win_hit)  cause_d = CAUSE_SHARE;
        else if (cnt_hit)              cause_d = CAUSE_COUNT;
        else                           cause_d = CAUSE_NONE;
        fire = (cause_d != CAUSE_NONE);
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FRESH, S_BOUNDARY: begin
                if (fire)        state_d = S_BOUNDARY;
                else if (shr_op) state_d = S_ARMED;
                else             state_d = S_FRESH;
            end
            S_ARMED: begin
                if (fire)        state_d = S_BOUNDARY;
                else             state_d = S_ARMED;
            end
            default:             state_d = S_FRESH;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_FRESH;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            if (fire) cause_q <= cause_d;
        end
    end

    // Outputs from state
    always_comb begin
        q_end   = 1'b0;
        q_cause = CAUSE_NONE;
        unique case (state_q)
            S_BOUNDARY: begin
                q_end   = 1'b1;
                q_cause = cause_q;
            end
            S_FRESH, S_ARMED: begin
                q_end   = 1'b0;
                q_cause = CAUSE_NONE;
            end
            default: begin
                q_end   = 1'b0;
                q_cause = CAUSE_NONE;
            end
        endcase
    end
endmodule

// File: rtl/qb_checker.sv
`timescale 1ns/1ps
module qb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_policy,
    input logic       ret_valid,
    input logic       ret_instrum,
    input logic       ret_mem,
    input logic       ret_shared,
    input logic       ret_unlock,
    input logic       ret_spin,
    input logic       q_end,
    input logic [1:0] q_cause
);
    // R11
    end_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_end |-> q_cause != 2'd0);

    // R11
    idle_no_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_end |-> q_cause == 2'd0);

    // R3
    sync_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_end && q_cause == 2'd2) |->
            ($past(cfg_policy[0]) && $past(ret_valid && !ret_instrum && (ret_unlock || ret_spin))));

    // R4
    share_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_end && q_cause == 2'd3) |->
            ($past(cfg_policy[1]) && $past(ret_valid && !ret_instrum && ret_mem && !ret_shared)));

    // R2
    count_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_end && q_cause == 2'd1) |-> $past(ret_valid && !ret_instrum));

    // R9
    invalid_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid |=> !q_end);

    // R8
    instrum_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_instrum) |=> !q_end);
endmodule

bind quantum_boundary_gen qb_checker u_qb_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_policy  (cfg_policy),
    .ret_valid   (ret_valid),
    .ret_instrum (ret_instrum),
    .ret_mem     (ret_mem),
    .ret_shared  (ret_shared),
    .ret_unlock  (ret_unlock),
    .ret_spin    (ret_spin),
    .q_end       (q_end),
    .q_cause     (q_cause)
);

// File: tb/sim_quantum_boundary_gen.sv
`timescale 1ns/1ps
module sim_quantum_boundary_gen;
    localparam int CNT_W = 16;
    localparam int WIN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       cfg_policy = 2'd0;
    logic [CNT_W-1:0] cfg_target = '0;
    logic [WIN_W-1:0] cfg_window = '0;
    logic ret_valid = 0, ret_instrum = 0, ret_mem = 0;
    logic ret_shared = 0, ret_unlock = 0, ret_spin = 0;
    logic             q_end;
    logic [1:0]       q_cause;

    always #2.5 clk = ~clk;

    quantum_boundary_gen #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_policy(cfg_policy),
        .cfg_target(cfg_target), .cfg_window(cfg_window),
        .ret_valid(ret_valid), .ret_instrum(ret_instrum), .ret_mem(ret_mem),
        .ret_shared(ret_shared), .ret_unlock(ret_unlock), .ret_spin(ret_spin),
        .q_end(q_end), .q_cause(q_cause)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    m_cnt, m_run;
    bit    m_armed;
    bit    exp_end;
    int    exp_cause;
    string exp_tag;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check_now();
        n_chk++;
        if (q_end !== exp_end || q_cause !== exp_cause[1:0]) begin
            n_fail++;
            $display("FAIL %s: q_end=%0b q_cause=%0d expected q_end=%0b q_cause=%0d",
                     exp_tag, q_end, q_cause, exp_end, exp_cause);
        end
    endtask

    // Called at a negedge: check, drive, predict, advance to next negedge.
    task automatic step(input bit v, input bit ins, input bit m, input bit s,
                        input bit u, input bit p, input string tag);
        bit counted, sync_hit, share_hit, cnt_hit;
        check_now();
        ret_valid = v; ret_instrum = ins; ret_mem = m;
        ret_shared = s; ret_unlock = u; ret_spin = p;
        counted   = v && !ins;
        sync_hit  = counted && (u || p) && cfg_policy[0];
        share_hit = cfg_policy[1] && m_armed && counted && m && !s
                    && (m_run + 1 >= int'(cfg_window));
        cnt_hit   = counted && (m_cnt + 1 >= int'(cfg_target));
        exp_cause = sync_hit ? 2 : share_hit ? 3 : cnt_hit ? 1 : 0;
        exp_end   = (exp_cause != 0);
        if (exp_end) begin
            m_cnt = 0; m_run = 0; m_armed = 0;
        end else begin
            if (counted) m_cnt++;
            if (counted && m) begin
                if (s) begin m_armed = 1; m_run = 0; end
                else if (m_armed) m_run++;
            end
        end
        if (tag != "") exp_tag = tag;
        else if (exp_cause == 2) exp_tag = (cfg_policy == 2'd3) ? "R6 sync" : "R3";
        else if (exp_cause == 3) exp_tag = (cfg_policy == 2'd3) ? "R6 share" : "R4";
        else if (exp_cause == 1) exp_tag = "R2";
        else exp_tag = "R11 R5 no boundary";
        @(negedge clk);
    endtask

    task automatic do_reset(input int pol, input int tgt, input int win);
        rst_n = 1'b0;
        ret_valid = 0; ret_instrum = 0; ret_mem = 0;
        ret_shared = 0; ret_unlock = 0; ret_spin = 0;
        cfg_policy = pol[1:0];
        cfg_target = tgt[CNT_W-1:0];
        cfg_window = win[WIN_W-1:0];
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0; m_run = 0; m_armed = 0;
        exp_end = 0; exp_cause = 0; exp_tag = "R1 reset";
        check_now();
    endtask

    task automatic rand_step();
        bit v, ins, m, s, u, p;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        v   = lfsr[0] | lfsr[1];
        ins = lfsr[2] & lfsr[3] & lfsr[4];
        m   = lfsr[5] | lfsr[8];
        s   = lfsr[6] & lfsr[7] & lfsr[8];
        u   = lfsr[9] & lfsr[10] & lfsr[11] & lfsr[12];
        p   = lfsr[13] & lfsr[14] & lfsr[15] & lfsr[3];
        step(v, ins, m, s, u, p, "");
    endtask

    initial begin
        #2ms;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int tgts[4];
        int wins[4];
        tgts = '{1, 2, 5, 9};
        wins = '{1, 2, 3, 6};
        @(negedge clk);
        // Sweep: every policy x target x window with a pseudo-random stream
        for (int pol = 0; pol < 4; pol++) begin
            for (int ti = 0; ti < 4; ti++) begin
                for (int wi = 0; wi < 4; wi++) begin
                    do_reset(pol, tgts[ti], wins[wi]);
                    for (int k = 0; k < 120; k++) rand_step();
                end
            end
        end

        // R8: instrumentation-only retirements with every flag set
        do_reset(3, 2, 1);
        step(1, 0, 1, 1, 0, 0, "R5 arm");
        for (int k = 0; k < 6; k++) step(1, 1, 1, 0, 1, 1, "R8 instrum ignored");
        step(1, 1, 1, 0, 0, 0, "R8 instrum ignored");
        // R9: invalid cycles with every flag set
        for (int k = 0; k < 6; k++) step(0, 0, 1, 0, 1, 1, "R9 invalid ignored");
        step(0, 0, 0, 0, 0, 0, "R9 invalid ignored");

        // R7: sync beats sharing and count in the same cycle
        do_reset(3, 2, 1);
        step(1, 0, 1, 1, 0, 0, "R7 arm");
        step(1, 0, 1, 0, 1, 0, "R7 sync over share and count");
        // R7: sharing beats count (new quantum starts in pulse cycle, R10)
        step(1, 0, 1, 1, 0, 0, "R10 pulse cycle arms new quantum");
        step(1, 0, 1, 0, 0, 0, "R7 share over count");
        step(0, 0, 0, 0, 0, 0, "R10 single pulse");

        // R5: no shared access, sharing never fires, count does
        do_reset(2, 6, 1);
        for (int k = 0; k < 5; k++) step(1, 0, 1, 0, 0, 0, "R5 window unarmed");
        step(1, 0, 1, 0, 0, 0, "R5 count only");
        step(0, 0, 0, 0, 0, 0, "R5 count only");

        // R3: sync flags ignored under count policy, effective under sync
        do_reset(0, 100, 1);
        for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 1, 1, "R3 ignored under policy 0");
        do_reset(1, 100, 1);
        for (int k = 0; k < 4; k++) step(1, 0, 0, 0, k[0], !k[0], "R10 back-to-back R3");
        step(0, 0, 0, 0, 0, 0, "R10 back-to-back R3");
        step(0, 0, 0, 0, 0, 0, "R10 pulse ends");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule